// File: doc/BRIEF.md
# External Bus Area Chip-Select Controller

This block turns requests from a 16-bit processor-side port into cycles on an external asynchronous bus shared by memories and peripherals. The top four bits of the 28-bit request address select one of up to eight areas. Each area that is switched on drives its own active-low chip select and has three fixed settings: a data width of 8 or 16 bits, a cycle length, and whether an external active-low wait line may stretch the cycle. The settings are parameters, and nothing can change them at run time.

A request is accepted in a clock where `req_valid` and `req_ready` are both high. The access starts in the next clock. Chip select and strobe stay asserted for the whole length of the access. If the access is a read, the read data is captured on the edge that ends the access. The requester then gets a single-clock `rsp_ack`, and the read data is on `rsp_rdata` in that same clock. A word request to a byte-wide area runs as two byte cycles, one after the other, and the requester sees only one ack. An address that matches no area produces no bus cycle. Such a request completes with an error flag.

The default map is as follows. Tag 0x0 selects select line 0: 16-bit, 2 clocks. Tag 0x1 selects line 1: 8-bit, waits on the external wait line. Tag 0xA selects line 2: 16-bit, 2 clocks. Tag 0x6 selects line 6: 8-bit, 3 clocks. Select lines 3, 4, 5 and 7 are never driven low.

Top module: `extbus_cs_ctrl`

## Requirements
- R1: The area is chosen by `req_addr[27:24]`. Tag 0x0 drives `bus_cs_n[0]`, tag 0x1 drives `bus_cs_n[1]`, tag 0xA drives `bus_cs_n[2]` and tag 0x6 drives `bus_cs_n[6]`. Select lines 3, 4, 5 and 7 stay high.
- R2: A tag that matches no area causes no chip select and no strobe. The request's `rsp_ack` and `rsp_err` are high together in the clock after acceptance, with `rsp_rdata` = 0. `rsp_err` is never high without `rsp_ack`.
- R3: Fixed-length areas keep chip select low for 1 clock plus the area's long-wait count: 2 clocks on lines 0 and 2, and 3 clocks on line 6. This holds for reads and writes, and `bus_wait_n` has no effect on these areas.
- R4: On an external-wait area (line 1), chip select is low for a base length of 2 clocks for a read and 3 clocks for a write. Every rising edge that ends the last base clock with `bus_wait_n` = 0 adds one clock. `bus_wait_n` has no effect in the earlier clocks of the cycle.
- R5: On 16-bit areas, a word access clears address bit 0, asserts both write strobes (`bus_wr_n` = 2'b00) and transfers all 16 bits. A byte access keeps the address and is big-endian. An even byte uses D[15:8] and `bus_wr_n` = 2'b01. An odd byte uses D[7:0] and `bus_wr_n` = 2'b10. Write bytes are driven on both lanes, and a read byte is returned in `rsp_rdata[7:0]` with the upper half zero.
- R6: On 8-bit areas, a byte uses lane D[7:0] only, with the low strobe only (`bus_wr_n` = 2'b10). The read byte is returned in `rsp_rdata[7:0]` with the upper half zero.
- R7: A word request to an 8-bit area runs two byte cycles. The first uses address bit 0 = 0 and carries `req_wdata[15:8]` or fills `rsp_rdata[15:8]`. The second uses address bit 0 = 1 and carries the low byte. There is no ack between the two cycles.
- R8: `rsp_ack` is a one-clock pulse in the clock that follows the last clock of the final bus cycle. Read data captured at the end of that cycle is on `rsp_rdata` in the ack clock.
- R9: At most one chip select is low at any time. A strobe is only asserted together with a chip select. All selects and strobes are high for at least one clock between two bus cycles.
- R10: `req_ready` is high only while the block is idle. An accepted mapped request starts its bus cycle in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this clock |
| req_addr | input | 28 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Unmapped address, valid with ack |
| rsp_rdata | output | 16 | Read data, valid with ack |
| bus_addr | output | 28 | External address |
| bus_cs_n | output | 8 | Active-low area chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 2 | Active-low write strobes, [1] upper lane, [0] lower lane |
| bus_wdata | output | 16 | External write data |
| bus_rdata | input | 16 | External read data |
| bus_wait_n | input | 1 | Active-low external wait |

## Verification
The case where two functions fall in the same clock is a word split on the wait-controlled area where the external wait is also held low in the last clock of the second byte cycle. In that clock, the stretch and the final capture-and-ack decision coincide. The bench provokes this in a directed test and in random traffic. It pulls wait low for a chosen number of final-clock edges on each half, and toggles wait at random in the earlier clocks. It then judges the measured chip-select lengths, the request-to-ack latency and the assembled read word against a model that applies the stretch to each half on its own.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  localparam int ADDR_W = 28;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int TAG_W  = 4;
  localparam int N_AREA = 8;
  localparam int IDX_W  = $clog2(N_AREA);
  localparam int LW_W   = 4;
  localparam int CNT_W  = LW_W + 1;
  localparam int LANES  = DATA_W / BYTE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_GAP} seq_st_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             is16;
    logic             xwait;
    logic [LW_W-1:0]  lwait;
  } area_info_t;

  // base clocks of one bus cycle before any external stretch
  function automatic logic [CNT_W-1:0] cyc_len(input logic xwait,
                                               input logic [LW_W-1:0] lwait,
                                               input logic wr);
    if (xwait) return wr ? CNT_W'(3) : CNT_W'(2);
    return CNT_W'(1) + CNT_W'(lwait);
  endfunction

  // active-high lane enables: [1] upper lane, [0] lower lane
  function automatic logic [LANES-1:0] lane_en(input logic is16, input logic word,
                                               input logic a0);
    if (!is16) return 2'b01;
    if (word)  return 2'b11;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  // byte handed to the bus for a byte-lane transfer
  function automatic logic [BYTE_W-1:0] out_byte(input logic split, input logic phase,
                                                 input logic [DATA_W-1:0] wd);
    if (split && !phase) return wd[DATA_W-1:BYTE_W];
    return wd[BYTE_W-1:0];
  endfunction

  // read value after one bus cycle is folded into the accumulated data
  function automatic logic [DATA_W-1:0] merge_rd(input logic is16, input logic word,
                                                 input logic a0, input logic phase,
                                                 input logic [DATA_W-1:0] acc,
                                                 input logic [DATA_W-1:0] bus);
    logic [BYTE_W-1:0] lo, hi;
    lo = bus[BYTE_W-1:0];
    hi = bus[DATA_W-1:BYTE_W];
    if (is16 && word) return bus;
    if (is16)         return {{BYTE_W{1'b0}}, (a0 ? lo : hi)};
    if (!word)        return {{BYTE_W{1'b0}}, lo};
    if (!phase)       return {lo, {BYTE_W{1'b0}}};
    return {acc[DATA_W-1:BYTE_W], lo};
  endfunction
endpackage

// File: rtl/extbus_area_dec.sv
module extbus_area_dec import extbus_pkg::*; #(
  parameter logic [N_AREA-1:0]       AREA_EN    = 8'b0100_0111,
  parameter logic [N_AREA*TAG_W-1:0] AREA_TAG   = 32'h0600_0A10,
  parameter logic [N_AREA-1:0]       AREA_IS16  = 8'b0000_0101,
  parameter logic [N_AREA-1:0]       AREA_XWAIT = 8'b0000_0010,
  parameter logic [N_AREA*LW_W-1:0]  AREA_LWAIT = 32'h0200_0101
) (
  input  logic [TAG_W-1:0] tag,
  output area_info_t       info
);
  logic [N_AREA-1:0] match;

  for (genvar g = 0; g < N_AREA; g++) begin : g_match
    assign match[g] = AREA_EN[g] && (tag == AREA_TAG[g*TAG_W +: TAG_W]);
  end

  // lowest matching index wins if a configuration overlaps
  always_comb begin
    info = '0;
    for (int i = N_AREA - 1; i >= 0; i--) begin
      if (match[i]) begin
        info.hit   = 1'b1;
        info.idx   = IDX_W'(i);
        info.is16  = AREA_IS16[i];
        info.xwait = AREA_XWAIT[i];
        info.lwait = AREA_LWAIT[i*LW_W +: LW_W];
      end
    end
  end
endmodule

// File: rtl/extbus_wait_timer.sv
module extbus_wait_timer import extbus_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  input  logic             xwait,
  input  logic             wait_n,
  output logic             last_clk,
  output logic             hold,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign last_clk = run && (cnt == CNT_W'(len - CNT_W'(1)));
  assign hold     = last_clk && xwait && !wait_n;
  assign done     = last_clk && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || done)  cnt <= '0;
    else if (!hold)         cnt <= cnt + CNT_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < len)); // R3
  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (run && last_clk)); // R4
  AST_FIXED_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !xwait) |-> !hold); // R3
endmodule

// File: rtl/extbus_steer.sv
module extbus_steer import extbus_pkg::*; (
  input  logic              is16,
  input  logic              word,
  input  logic              phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rd_acc,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  lanes,
  output logic [DATA_W-1:0] rd_next
);
  logic split;
  logic [BYTE_W-1:0] wbyte;

  assign split = word && !is16;
  assign wbyte = out_byte(split, phase, wdata);

  always_comb begin
    if (!word)      bus_addr = addr;
    else if (is16)  bus_addr = {addr[ADDR_W-1:1], 1'b0};
    else            bus_addr = {addr[ADDR_W-1:1], phase};
  end

  assign bus_wdata = (is16 && word) ? wdata : {LANES{wbyte}};
  assign lanes     = lane_en(is16, word, addr[0]);
  assign rd_next   = merge_rd(is16, word, addr[0], phase, rd_acc, bus_rdata);
endmodule

// File: rtl/extbus_cs_ctrl.sv
module extbus_cs_ctrl import extbus_pkg::*; #(
  parameter logic [N_AREA-1:0]       AREA_EN    = 8'b0100_0111,
  parameter logic [N_AREA*TAG_W-1:0] AREA_TAG   = 32'h0600_0A10,
  parameter logic [N_AREA-1:0]       AREA_IS16  = 8'b0000_0101,
  parameter logic [N_AREA-1:0]       AREA_XWAIT = 8'b0000_0010,
  parameter logic [N_AREA*LW_W-1:0]  AREA_LWAIT = 32'h0200_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [N_AREA-1:0] bus_cs_n,
  output logic              bus_rd_n,
  output logic [LANES-1:0]  bus_wr_n,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_wait_n
);
  seq_st_e          st;
  area_info_t       dec;
  logic [IDX_W-1:0] t_idx;
  logic             t_is16, t_xwait, t_wr, t_word, phase, pend2;
  logic [LW_W-1:0]  t_lwait;
  logic [ADDR_W-1:0] t_addr;
  logic [DATA_W-1:0] t_wdata, rd_acc, rd_next;
  logic [LANES-1:0] lanes;
  logic [CNT_W-1:0] len;
  logic             in_access, accept, t_split;
  logic             last_clk, hold, done;

  assign in_access = (st == ST_ACCESS);
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign t_split   = t_word && !t_is16;
  assign len       = cyc_len(t_xwait, t_lwait, t_wr);

  extbus_area_dec #(
    .AREA_EN(AREA_EN), .AREA_TAG(AREA_TAG), .AREA_IS16(AREA_IS16),
    .AREA_XWAIT(AREA_XWAIT), .AREA_LWAIT(AREA_LWAIT)
  ) u_dec (
    .tag  (req_addr[ADDR_W-1 -: TAG_W]),
    .info (dec)
  );

  extbus_wait_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (in_access),
    .len      (len),
    .xwait    (t_xwait),
    .wait_n   (bus_wait_n),
    .last_clk (last_clk),
    .hold     (hold),
    .done     (done)
  );

  extbus_steer u_steer (
    .is16      (t_is16),
    .word      (t_word),
    .phase     (phase),
    .addr      (t_addr),
    .wdata     (t_wdata),
    .rd_acc    (rd_acc),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .lanes     (lanes),
    .rd_next   (rd_next)
  );

  for (genvar g = 0; g < N_AREA; g++) begin : g_cs
    assign bus_cs_n[g] = !(in_access && (t_idx == IDX_W'(g)));
  end

  assign bus_rd_n  = !(in_access && !t_wr);
  assign bus_wr_n  = (in_access && t_wr) ? ~lanes : '1;
  assign rsp_rdata = rd_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      t_idx   <= '0;
      t_is16  <= 1'b0;
      t_xwait <= 1'b0;
      t_lwait <= '0;
      t_wr    <= 1'b0;
      t_word  <= 1'b0;
      t_addr  <= '0;
      t_wdata <= '0;
      phase   <= 1'b0;
      pend2   <= 1'b0;
      rd_acc  <= '0;
      rsp_ack <= 1'b0;
      rsp_err <= 1'b0;
    end else begin
      rsp_ack <= 1'b0;
      rsp_err <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            t_idx   <= dec.idx;
            t_is16  <= dec.is16;
            t_xwait <= dec.xwait;
            t_lwait <= dec.lwait;
            t_wr    <= req_write;
            t_word  <= req_word;
            t_addr  <= req_addr;
            t_wdata <= req_wdata;
            phase   <= 1'b0;
            pend2   <= 1'b0;
            rd_acc  <= '0;
            if (dec.hit) begin
              st <= ST_ACCESS;
            end else begin
              rsp_ack <= 1'b1;
              rsp_err <= 1'b1;
            end
          end
        end
        ST_ACCESS: begin
          if (done) begin
            if (!t_wr) rd_acc <= rd_next;
            st <= ST_GAP;
            if (t_split && !phase) pend2   <= 1'b1;
            else                   rsp_ack <= 1'b1;
          end
        end
        ST_GAP: begin
          if (pend2) begin
            pend2 <= 1'b0;
            phase <= 1'b1;
            st    <= ST_ACCESS;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)); // R9
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || (bus_wr_n != '1)) |-> (bus_cs_n != '1)); // R9
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((bus_cs_n == '1) && bus_rd_n && (bus_wr_n == '1))); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack); // R8
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_ack); // R2
  AST_MISS_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec.hit) |=> (rsp_ack && rsp_err && (bus_cs_n == '1))); // R2
  AST_HIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.hit) |=> (bus_cs_n != '1)); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n == '1)); // R10
  AST_SPLIT_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && t_split && !phase) |=> !rsp_ack); // R7
  AST_WAIT_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(bus_cs_n)); // R4
  AST_UNUSED_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_n & ~AREA_EN) == (~AREA_EN)); // R1
endmodule

// File: tb/extbus_cs_ctrl_tb.sv
module extbus_cs_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [27:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_ack, rsp_err;
  logic [15:0] rsp_rdata;
  logic [27:0] bus_addr;
  logic [7:0]  bus_cs_n;
  logic        bus_rd_n;
  logic [1:0]  bus_wr_n;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_wait_n = 1'b1;

  int n_chk = 0, n_fail = 0;
  int cur_L = 1, cur_S = 0;
  int n_log = 0, pos = 0, stretch_left = 0;
  int bad_multi = 0, bad_strobe = 0;
  logic [7:0]  prev_csl = '0;
  int          lg_idx [4];
  logic [27:0] lg_addr [4];
  logic        lg_rd [4];
  logic [1:0]  lg_wrn [4];
  logic [15:0] lg_wd [4];
  int          lg_len [4];

  always #4 clk = ~clk;

  extbus_cs_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
    .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_wait_n(bus_wait_n)
  );

  function automatic logic [15:0] pat16(input logic [27:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ a[23:16] ^ 8'h3C};
  endfunction
  function automatic logic [7:0] pat8(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ {a[27:24], 4'h5};
  endfunction
  function automatic bit mapped(input logic [3:0] t);
    return t == 4'h0 || t == 4'h1 || t == 4'hA || t == 4'h6;
  endfunction
  function automatic int area_of(input logic [3:0] t);
    case (t) 4'h0: return 0; 4'h1: return 1; 4'hA: return 2; default: return 6; endcase
  endfunction
  function automatic int base_len(input logic [3:0] t, input bit wr);
    case (t) 4'h1: return wr ? 3 : 2; 4'h6: return 3; default: return 2; endcase
  endfunction

  // external devices: word devices ignore A0, byte devices put junk on the upper lane
  assign bus_rdata = (!bus_cs_n[0] || !bus_cs_n[2]) ? pat16({bus_addr[27:1], 1'b0})
                                                    : {~pat8(bus_addr), pat8(bus_addr)};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor and wait driver
  always @(negedge clk) begin
    logic [7:0] csl;
    csl = ~bus_cs_n;
    if (csl == 8'h00) begin
      if (!bus_rd_n || bus_wr_n != 2'b11) bad_strobe++;
      bus_wait_n = 1'($urandom_range(0, 1));
    end else begin
      if ($countones(csl) > 1) bad_multi++;
      if (prev_csl == 8'h00) begin
        if (n_log < 4) begin
          for (int i = 0; i < 8; i++) if (csl[i]) lg_idx[n_log] = i;
          lg_addr[n_log] = bus_addr;
          lg_rd[n_log]   = !bus_rd_n;
          lg_wrn[n_log]  = bus_wr_n;
          lg_wd[n_log]   = bus_wdata;
          lg_len[n_log]  = 0;
        end
        n_log++;
        pos = 1;
        stretch_left = cur_S;
      end else begin
        pos++;
      end
      if (n_log <= 4) lg_len[n_log-1] = pos;
      if (csl[1]) begin
        if (pos < cur_L) bus_wait_n = 1'($urandom_range(0, 1));
        else if (stretch_left > 0) begin bus_wait_n = 1'b0; stretch_left--; end
        else bus_wait_n = 1'b1;
      end else begin
        bus_wait_n = 1'($urandom_range(0, 1));
      end
    end
    prev_csl = csl;
  end

  task automatic do_txn(input logic [27:0] a, input bit wr, input bit word,
                        input logic [15:0] wd, input int s);
    logic [3:0] t;
    bit hit, is16, split, busy_ready;
    int L, nc, lat, exp_lat;
    logic [27:0] ea;
    logic [15:0] er;
    logic [7:0] b;
    t = a[27:24];
    hit = mapped(t);
    is16 = (t == 4'h0 || t == 4'hA);
    split = word && !is16;
    L = base_len(t, wr);
    cur_L = L;
    cur_S = (t == 4'h1) ? s : 0;
    nc = !hit ? 0 : (split ? 2 : 1);
    while (!req_ready) @(negedge clk);
    n_log = 0;
    req_addr = a; req_write = wr; req_word = word; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_ready = 1'b0;
    while (!rsp_ack && lat < 400) begin
      if (req_ready) busy_ready = 1'b1;
      @(negedge clk);
      lat++;
    end
    exp_lat = !hit ? 1 : nc * (L + cur_S + 1);
    chk(lat == exp_lat, hit ? "R8 ack latency" : "R2 miss latency", lat, exp_lat);
    chk(rsp_err == !hit, "R2 error flag", rsp_err, !hit);
    chk(n_log == nc, split ? "R7 cycle count" : "R1 cycle count", n_log, nc);
    if (hit) chk(!busy_ready, "R10 ready while busy", busy_ready, 0);
    for (int k = 0; k < nc && k < n_log; k++) begin
      chk(lg_idx[k] == area_of(t), "R1 select line", lg_idx[k], area_of(t));
      chk(lg_len[k] == L + cur_S, (t == 4'h1) ? "R4 cycle length" : "R3 cycle length",
          lg_len[k], L + cur_S);
      chk(lg_rd[k] == !wr, "R9 read strobe", lg_rd[k], !wr);
      if (split)      ea = {a[27:1], 1'(k)};
      else if (word)  ea = {a[27:1], 1'b0};
      else            ea = a;
      chk(lg_addr[k] == ea, split ? "R7 address" : (is16 ? "R5 address" : "R6 address"),
          lg_addr[k], ea);
      if (wr) begin
        b = split ? (k == 0 ? wd[15:8] : wd[7:0]) : wd[7:0];
        if (is16 && word) begin
          chk(lg_wrn[k] == 2'b00, "R5 word strobes", lg_wrn[k], 2'b00);
          chk(lg_wd[k] == wd, "R5 word data", lg_wd[k], wd);
        end else if (is16) begin
          chk(lg_wrn[k] == (a[0] ? 2'b10 : 2'b01), "R5 byte strobe", lg_wrn[k],
              a[0] ? 2'b10 : 2'b01);
          chk(lg_wd[k] == {b, b}, "R5 byte data", lg_wd[k], {b, b});
        end else begin
          chk(lg_wrn[k] == 2'b10, split ? "R7 strobe" : "R6 strobe", lg_wrn[k], 2'b10);
          chk(lg_wd[k][7:0] == b, split ? "R7 byte order" : "R6 byte data",
              lg_wd[k][7:0], b);
        end
      end else begin
        chk(lg_wrn[k] == 2'b11, "R9 no write strobe", lg_wrn[k], 2'b11);
      end
    end
    if (!hit) begin
      chk(rsp_rdata == 16'h0, "R2 zero data", rsp_rdata, 0);
    end else if (!wr) begin
      if (is16 && word)  er = pat16({a[27:1], 1'b0});
      else if (is16)     er = a[0] ? {8'h00, pat16({a[27:1], 1'b0})[7:0]}
                                   : {8'h00, pat16({a[27:1], 1'b0})[15:8]};
      else if (!word)    er = {8'h00, pat8(a)};
      else               er = {pat8({a[27:1], 1'b0}), pat8({a[27:1], 1'b1})};
      chk(rsp_rdata == er, split ? "R7 read assembly" : (is16 ? "R5 read data" : "R6 read data"),
          rsp_rdata, er);
    end
    @(negedge clk);
    chk(!rsp_ack, "R8 ack single pulse", rsp_ack, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(bus_cs_n == 8'hFF, "R9 reset selects", bus_cs_n, 8'hFF);
    chk(bus_rd_n && bus_wr_n == 2'b11, "R9 reset strobes", {bus_rd_n, bus_wr_n}, 3'b111);
    chk(!rsp_ack && !rsp_err, "R8 reset ack", {rsp_ack, rsp_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10 ready after reset", req_ready, 1);
    // directed corners
    do_txn(28'h1000456, 1'b0, 1'b1, 16'h0, 3);   // split + wait in final clock of both halves
    do_txn(28'h1000457, 1'b1, 1'b1, 16'hBEEF, 2);
    do_txn(28'h3123456, 1'b0, 1'b1, 16'h0, 0);   // unmapped
    do_txn(28'hF000001, 1'b1, 1'b0, 16'h00AA, 0);
    do_txn(28'h6000010, 1'b1, 1'b1, 16'hC3D4, 0);
    do_txn(28'hA000013, 1'b1, 1'b0, 16'h0077, 0);
    do_txn(28'hA000012, 1'b0, 1'b0, 16'h0, 0);
    do_txn(28'h0000101, 1'b0, 1'b1, 16'h0, 0);
    do_txn(28'h1000020, 1'b0, 1'b0, 16'h0, 0);
    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [3:0] tg;
      case ($urandom_range(0, 7))
        0: tg = 4'h0; 1: tg = 4'h1; 2: tg = 4'hA; 3: tg = 4'h6;
        4: tg = 4'h1; 5: tg = 4'h3; 6: tg = 4'hB; default: tg = 4'h5;
      endcase
      do_txn({tg, 24'($urandom)}, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             16'($urandom), $urandom_range(0, 3));
    end
    chk(bad_multi == 0, "R9 one select at a time", bad_multi, 0);
    chk(bad_strobe == 0, "R9 strobe without select", bad_strobe, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule